// File: doc/BRIEF.md
# Pixel to parallel bus cycle packer

This block sits between a pixel stream and a narrow parallel display bus. It takes one pixel at a time (12, 16, 18 or 24 significant bits) and cuts it into a short run of bus words for a bus that is 8, 9, 12 or 16 lines wide. The bus timing and strobes are generated elsewhere. This block only decides how many words a pixel needs and which bits go into each word.

Three static inputs set the pixel data type, the bus width and the cycle format. The block works out for itself which cycle format fits the chosen data type and bus width. If the supplied format does not match that choice, or if no format fits, it raises an error and stops taking pixels. In the fractional format, two pixels share three bus words. The middle word carries the tail of the first pixel and the head of the second.

Both sides use valid/ready handshakes. Each word carries a flag that marks the final word of its pixel, or of its pixel pair in the fractional format.

Top module: `pixbus_packer`

## Requirements
- R1: `config_error_o` is high when no cycle format fits the data type and bus width, or when `fmt_i` differs from the fitting format. While it is high, `pix_ready_o` is low and no word is produced from pixels offered during that time.
- R2: Codes are as follows. `dtype_i` 0/1/2/3 selects 12/16/18/24 bits. `width_i` 0/1/2/3 selects 8/9/12/16 lines. `fmt_i` 0/1/2/3 selects one, two or three words per pixel, or three words per two pixels. The fitting format is the whole ratio bits/lines when that ratio is 1, 2 or 3. Otherwise it is format 3 when 2·bits/lines = 3. The legal pairs are therefore 12/12 and 16/16 (format 0), 16/8, 18/9 and 24/12 (format 1), 24/8 (format 2), and 12/8, 18/12 and 24/16 (format 3).
- R3: A pixel is sent most significant slice first. Each word holds its slice in `word_o` bits [L-1:0], where L is the line count, and every bit above L is zero. For 16 bits on 8 lines, the words are pixel[15:8] and then pixel[7:0].
- R4: A 24-bit pixel on 8 lines gives three words: [23:16], then [15:8], then [7:0].
- R5: In format 0, a pixel gives a single word that carries all of its bits, and that word has `word_last_o` set.
- R6: In format 3, with pixel A accepted before pixel B and line count L, the words are as follows. Word 0 is the top L bits of A. Word 1 has the remaining L/2 bits of A in its upper half and the top L/2 bits of B in its lower half. Word 2 is the low L bits of B.
- R7: Pixel bits above the selected data width have no effect on any word.
- R8: `pix_ready_o` stays low from the acceptance of the pixel that completes a group until the last word of that group is accepted. It is high again on the next cycle. Between the two pixels of a format 3 pair it stays high and no word is offered.
- R9: While `word_valid_o` is high and `word_ready_i` is low, `word_o`, `word_last_o` and `word_valid_o` hold their values.
- R10: `word_last_o` is high only on the final word of a group, and only together with `word_valid_o`.
- R11: After reset `word_valid_o` is low, and with a legal configuration `pix_ready_o` is high. An asynchronous reset in the middle of a group drops the pending words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dtype_i | input | 2 | Pixel data type code |
| width_i | input | 2 | Bus width code |
| fmt_i | input | 2 | Cycle format code |
| pix_i | input | PIX_W | Pixel, right-aligned |
| pix_valid_i | input | 1 | Pixel offered |
| pix_ready_o | output | 1 | Pixel can be taken |
| word_o | output | BUS_W | Bus word, right-aligned |
| word_valid_o | output | 1 | Bus word offered |
| word_ready_i | input | 1 | Bus word taken |
| word_last_o | output | 1 | Final word of pixel or pair |
| config_error_o | output | 1 | Configuration has no fitting format |

## Verification
The first word of a group appears one clock after the edge that accepts the group's last pixel. Each later word appears one clock after the edge that consumed the one before it. `pix_ready_o` returns one clock after the final word is consumed. `config_error_o` is purely combinational and follows the configuration inputs at once. The bench changes every input on the falling edge and reads every output at a falling edge, half a period after the edge that caused it. It raises `word_ready_i` for exactly one rising edge per word, so each word is checked in the cycle it is due and held words can be observed under backpressure.

// File: rtl/pixbus_packer_pkg.sv
package pixbus_packer_pkg;
  typedef enum logic [1:0] {
    FMT_1X1 = 2'd0,
    FMT_2X1 = 2'd1,
    FMT_3X1 = 2'd2,
    FMT_3X2 = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HALF = 2'd1,
    ST_EMIT = 2'd2
  } seq_st_e;
endpackage

// File: rtl/pixbus_cfg_decode.sv
module pixbus_cfg_decode
  import pixbus_packer_pkg::*;
#(
  parameter int SH_W = 6
) (
  input  logic [1:0]      dtype_i,
  input  logic [1:0]      width_i,
  input  logic [1:0]      fmt_i,
  output logic [SH_W-1:0] bpp_o,
  output logic [SH_W-1:0] lines_o,
  output logic [1:0]      nwords_o,
  output logic            pair_o,
  output logic            err_o
);
  fmt_e fit;
  logic fit_ok;

  always_comb begin
    unique case (dtype_i)
      2'd0:    bpp_o = SH_W'(12);
      2'd1:    bpp_o = SH_W'(16);
      2'd2:    bpp_o = SH_W'(18);
      default: bpp_o = SH_W'(24);
    endcase
    unique case (width_i)
      2'd0:    lines_o = SH_W'(8);
      2'd1:    lines_o = SH_W'(9);
      2'd2:    lines_o = SH_W'(12);
      default: lines_o = SH_W'(16);
    endcase
  end

  always_comb begin
    fit    = FMT_1X1;
    fit_ok = 1'b1;
    if (bpp_o == lines_o)                      fit = FMT_1X1;
    else if (bpp_o == (lines_o << 1))          fit = FMT_2X1;
    else if (bpp_o == lines_o + (lines_o << 1)) fit = FMT_3X1;
    else if ((bpp_o << 1) == lines_o + (lines_o << 1)) fit = FMT_3X2;
    else fit_ok = 1'b0;
  end

  always_comb begin
    unique case (fit)
      FMT_1X1: nwords_o = 2'd1;
      FMT_2X1: nwords_o = 2'd2;
      default: nwords_o = 2'd3;
    endcase
  end

  assign pair_o = (fit == FMT_3X2);
  assign err_o  = !fit_ok || (fmt_e'(fmt_i) != fit);
endmodule

// File: rtl/pixbus_seq.sv
module pixbus_seq
  import pixbus_packer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       err_i,
  input  logic       pair_i,
  input  logic [1:0] nwords_i,
  input  logic       pix_valid_i,
  output logic       pix_ready_o,
  input  logic       word_ready_i,
  output logic       word_valid_o,
  output logic       word_last_o,
  output logic       load_a_o,
  output logic       load_b_o,
  output logic [1:0] idx_o
);
  seq_st_e st_q;
  logic [1:0] idx_q;
  logic pix_fire, word_fire, at_last;

  assign pix_ready_o  = !err_i && (st_q != ST_EMIT);
  assign pix_fire     = pix_valid_i && pix_ready_o;
  assign word_valid_o = (st_q == ST_EMIT);
  assign at_last      = (idx_q == nwords_i - 2'd1);
  assign word_last_o  = word_valid_o && at_last;
  assign word_fire    = word_valid_o && word_ready_i;
  assign load_a_o     = pix_fire && (st_q == ST_IDLE);
  assign load_b_o     = pix_fire && (st_q == ST_HALF);
  assign idx_o        = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pix_fire) begin
          st_q  <= pair_i ? ST_HALF : ST_EMIT;
          idx_q <= '0;
        end
        ST_HALF: if (pix_fire) st_q <= ST_EMIT;
        default: if (word_fire) begin
          if (at_last) st_q <= ST_IDLE;
          idx_q <= at_last ? 2'd0 : idx_q + 2'd1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pixbus_group.sv
module pixbus_group #(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16,
  parameter int GRP_W = 48,
  parameter int SH_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_a_i,
  input  logic             load_b_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [SH_W-1:0]  bpp_i,
  input  logic [SH_W-1:0]  lines_i,
  input  logic [1:0]       idx_i,
  output logic [BUS_W-1:0] word_o
);
  logic [GRP_W-1:0] pix_m, grp_q, grp_sh;
  logic [BUS_W-1:0] head;

  // keep only the selected data width
  assign pix_m = GRP_W'(pix_i) & ((GRP_W'(1) << bpp_i) - GRP_W'(1));

  // group is left-justified: first pixel at the top, second right below it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       grp_q <= '0;
    else if (load_a_i) grp_q <= pix_m << (SH_W'(GRP_W) - bpp_i);
    else if (load_b_i) grp_q <= grp_q | (pix_m << (SH_W'(GRP_W) - (bpp_i << 1)));
  end

  assign grp_sh = grp_q << (SH_W'(idx_i) * lines_i);
  assign head   = grp_sh[GRP_W-1 -: BUS_W];
  assign word_o = head >> (SH_W'(BUS_W) - lines_i);
endmodule

// File: rtl/pixbus_packer.sv
module pixbus_packer #(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       dtype_i,
  input  logic [1:0]       width_i,
  input  logic [1:0]       fmt_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  output logic [BUS_W-1:0] word_o,
  output logic             word_valid_o,
  input  logic             word_ready_i,
  output logic             word_last_o,
  output logic             config_error_o
);
  localparam int GRP_W = 2 * PIX_W;
  localparam int SH_W  = $clog2(GRP_W + BUS_W + 1);

  logic [SH_W-1:0] bpp, lines;
  logic [1:0] nwords, idx;
  logic pair, err, load_a, load_b;

  pixbus_cfg_decode #(.SH_W(SH_W)) u_cfg (
    .dtype_i (dtype_i),
    .width_i (width_i),
    .fmt_i   (fmt_i),
    .bpp_o   (bpp),
    .lines_o (lines),
    .nwords_o(nwords),
    .pair_o  (pair),
    .err_o   (err)
  );

  pixbus_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_i       (err),
    .pair_i      (pair),
    .nwords_i    (nwords),
    .pix_valid_i (pix_valid_i),
    .pix_ready_o (pix_ready_o),
    .word_ready_i(word_ready_i),
    .word_valid_o(word_valid_o),
    .word_last_o (word_last_o),
    .load_a_o    (load_a),
    .load_b_o    (load_b),
    .idx_o       (idx)
  );

  pixbus_group #(.PIX_W(PIX_W), .BUS_W(BUS_W), .GRP_W(GRP_W), .SH_W(SH_W)) u_grp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_a_i(load_a),
    .load_b_i(load_b),
    .pix_i   (pix_i),
    .bpp_i   (bpp),
    .lines_i (lines),
    .idx_i   (idx),
    .word_o  (word_o)
  );

  assign config_error_o = err;
endmodule

// File: rtl/pixbus_packer_chk.sv
module pixbus_packer_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_ready_o,
  input logic [BUS_W-1:0] word_o,
  input logic             word_valid_o,
  input logic             word_ready_i,
  input logic             word_last_o,
  input logic             config_error_o
);
  // R1
  a_r1_err_blocks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    config_error_o |-> !pix_ready_o);

  // R8
  a_r8_no_ready_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> !pix_ready_o);

  a_r8_ready_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && word_ready_i && word_last_o && !config_error_o) |=> pix_ready_o);

  // R9
  a_r9_hold_under_backpressure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !word_ready_i) |=>
      (word_valid_o && $stable(word_o) && $stable(word_last_o)));

  // R10
  a_r10_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_last_o |-> word_valid_o);
endmodule

bind pixbus_packer pixbus_packer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pix_ready_o   (pix_ready_o),
  .word_o        (word_o),
  .word_valid_o  (word_valid_o),
  .word_ready_i  (word_ready_i),
  .word_last_o   (word_last_o),
  .config_error_o(config_error_o)
);

// File: tb/pixbus_packer_tb.sv
module pixbus_packer_tb;
  localparam int PIX_W = 24;
  localparam int BUS_W = 16;
  localparam int NROW  = 9;

  // {dtype, width, fmt, pix_a, pix_b, nwords, w0, w1, w2}
  localparam logic [103:0] VEC [NROW] = '{
    {2'd1, 2'd0, 2'd1, 24'hFFA1B2, 24'h000000, 2'd2, 16'h00A1, 16'h00B2, 16'h0000},
    {2'd3, 2'd0, 2'd2, 24'hC3D4E5, 24'h000000, 2'd3, 16'h00C3, 16'h00D4, 16'h00E5},
    {2'd1, 2'd3, 2'd0, 24'h5ABEEF, 24'h000000, 2'd1, 16'hBEEF, 16'h0000, 16'h0000},
    {2'd0, 2'd2, 2'd0, 24'hFFFABC, 24'h000000, 2'd1, 16'h0ABC, 16'h0000, 16'h0000},
    {2'd2, 2'd1, 2'd1, 24'hEEB5A7, 24'h000000, 2'd2, 16'h015A, 16'h01A7, 16'h0000},
    {2'd3, 2'd2, 2'd1, 24'h123456, 24'h000000, 2'd2, 16'h0123, 16'h0456, 16'h0000},
    {2'd0, 2'd0, 2'd3, 24'hFFFABC, 24'h000DEF, 2'd3, 16'h00AB, 16'h00CD, 16'h00EF},
    {2'd2, 2'd2, 2'd3, 24'h012345, 24'h02ABCD, 2'd3, 16'h048D, 16'h016A, 16'h0BCD},
    {2'd3, 2'd3, 2'd3, 24'h112233, 24'h445566, 2'd3, 16'h1122, 16'h3344, 16'h5566}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] dtype, width, fmt;
  logic [PIX_W-1:0] pix;
  logic pix_valid, pix_ready, word_valid, word_ready, word_last, cfg_err;
  logic [BUS_W-1:0] word;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pixbus_packer #(.PIX_W(PIX_W), .BUS_W(BUS_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dtype_i(dtype), .width_i(width), .fmt_i(fmt),
    .pix_i(pix), .pix_valid_i(pix_valid), .pix_ready_o(pix_ready),
    .word_o(word), .word_valid_o(word_valid), .word_ready_i(word_ready),
    .word_last_o(word_last), .config_error_o(cfg_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] d, input logic [1:0] w, input logic [1:0] f);
    @(negedge clk);
    dtype = d; width = w; fmt = f;
    #1;
  endtask

  task automatic push(input logic [PIX_W-1:0] p);
    @(negedge clk);
    pix = p;
    pix_valid = 1'b1;
    while (!pix_ready) @(negedge clk);
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic get_word(input string req, input logic [BUS_W-1:0] exp_w, input logic exp_last);
    while (!word_valid) @(negedge clk);
    check(req, 32'(word), 32'(exp_w));
    check("R10 last flag", 32'(word_last), 32'(exp_last));
    word_ready = 1'b1;
    @(negedge clk);
    word_ready = 1'b0;
  endtask

  function automatic string row_tag(input int i);
    case (i)
      0: return "R3 16b on 8 lines";
      1: return "R4 24b on 8 lines";
      2: return "R5 16b on 16 lines";
      3: return "R7 12b on 12 lines";
      4: return "R2 18b on 9 lines";
      5: return "R2 24b on 12 lines";
      default: return "R6 three words per pair";
    endcase
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    dtype = 2'd1; width = 2'd3; fmt = 2'd0;
    pix = '0; pix_valid = 1'b0; word_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check("R11 valid after reset", 32'(word_valid), 32'd0);
    check("R11 ready after reset", 32'(pix_ready), 32'd1);
    check("R11 no error on legal cfg", 32'(cfg_err), 32'd0);
    check("R10 last low after reset", 32'(word_last), 32'd0);

    for (int i = 0; i < NROW; i++) begin
      logic [103:0] v;
      logic [BUS_W-1:0] exp_w [3];
      int nw;
      v = VEC[i];
      exp_w[0] = v[47:32]; exp_w[1] = v[31:16]; exp_w[2] = v[15:0];
      nw = int'(v[49:48]);
      set_cfg(v[103:102], v[101:100], v[99:98]);
      check("R2 legal pair accepted", 32'(cfg_err), 32'd0);
      push(v[97:74]);
      if (v[99:98] == 2'd3) begin
        // R8 between the two pixels of a pair
        check("R8 ready between pair", 32'(pix_ready), 32'd1);
        check("R8 no word before pair", 32'(word_valid), 32'd0);
        push(v[73:50]);
      end
      check("R8 ready withheld", 32'(pix_ready), 32'd0);
      for (int k = 0; k < nw; k++)
        get_word(row_tag(i), exp_w[k], k == nw - 1);
      check("R8 ready after last word", 32'(pix_ready), 32'd1);
      check("R8 nothing left over", 32'(word_valid), 32'd0);
    end

    // R9 backpressure on a three-word pixel
    set_cfg(2'd3, 2'd0, 2'd2);
    push(24'h0A0B0C);
    repeat (3) @(negedge clk);
    check("R9 word held", 32'(word), 32'h0A);
    check("R9 valid held", 32'(word_valid), 32'd1);
    check("R9 last low on first word", 32'(word_last), 32'd0);
    check("R8 ready low under backpressure", 32'(pix_ready), 32'd0);
    get_word("R9 word 0", 16'h000A, 1'b0);
    get_word("R9 word 1", 16'h000B, 1'b0);
    get_word("R9 word 2", 16'h000C, 1'b1);

    // R11 reset mid-group drops pending words
    push(24'h010203);
    check("R11 group pending", 32'(word_valid), 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 async reset clears valid", 32'(word_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R11 ready after mid reset", 32'(pix_ready), 32'd1);

    // R1 illegal combinations
    set_cfg(2'd1, 2'd1, 2'd0);
    check("R1 16b on 9 lines", 32'(cfg_err), 32'd1);
    check("R1 ready low on error", 32'(pix_ready), 32'd0);
    set_cfg(2'd0, 2'd3, 2'd3);
    check("R1 12b on 16 lines", 32'(cfg_err), 32'd1);
    set_cfg(2'd1, 2'd0, 2'd0);
    check("R1 format mismatch", 32'(cfg_err), 32'd1);
    check("R1 ready low on mismatch", 32'(pix_ready), 32'd0);
    @(negedge clk);
    pix = 24'h00BEEF;
    pix_valid = 1'b1;
    repeat (3) @(negedge clk);
    pix_valid = 1'b0;
    set_cfg(2'd1, 2'd3, 2'd0);
    check("R1 legal again", 32'(cfg_err), 32'd0);
    check("R1 pixel offered on error ignored", 32'(word_valid), 32'd0);
    check("R1 ready back", 32'(pix_ready), 32'd1);

    summary();
    $finish;
  end
endmodule